// File: doc/BRIEF.md
# Audio Sample Playback Controller

The block plays a stretch of audio held in a byte-addressed RAM. Software sets a start address, a byte length, a sample rate in Hz, a format, a loop flag and a volume, then pulses a play write. The sequencer fetches bytes over a request/valid read port. A phase-accumulator pacer times each sample. The selected decoder expands each byte, or each nibble for ADPCM, to a signed 16-bit value. That value is scaled by the volume and presented with a one-cycle strobe.

Three formats share one sequencer: signed 8-bit PCM, mu-law, and 4-bit IMA-style ADPCM with two codes per byte. The busy output mirrors the play flag and can be read as a live status. A play write with a length below eight bytes acts as a stop command.

Top module: `audio_player`

## Requirements
- R1: `cfgFormat` selects the decoder: 0 is 8-bit signed PCM, 1 is mu-law, 2 is ADPCM.
- R2: In PCM mode each byte is taken as a two's-complement value and shifted left by 8 to form the 16-bit sample.
- R3: Bits 2:0 of `cfgStart` and `cfgLength` are ignored. Playback begins at the start address with those bits cleared and covers length with those bits cleared, in bytes.
- R4: A `playWr` pulse with an effective length of at least 8 raises `playBusy` on the next cycle. In single-shot mode (`cfgLoop`=0), `playBusy` falls once the last sample of the buffer has been issued.
- R5: With `cfgLoop`=1, after the last byte the address wraps to the start and playback continues. The ADPCM predictor and step index return to 0 at every start and every wrap, so each pass repeats the same samples.
- R6: A `playWr` pulse whose effective length is 0 stops any playback. `playBusy` is 0 on the next cycle, and no further sample strobes or memory requests follow.
- R7: In ADPCM mode the code in bits 3:0 is played before the code in bits 7:4. Decoding works as follows:
  - The difference is step>>3, plus step for code bit 2, plus step>>1 for code bit 1, plus step>>2 for code bit 0.
  - Code bit 3 makes the difference negative. The predictor is clamped to -32768..32767.
  - The index moves by -1 for codes whose bits 2:0 are 0..3, and by 2*(bits 1:0)+2 otherwise. It is clamped to 0..88.
  - The step table starts at step[0]=7. Each entry is step[n+1]=min(32767, step[n]+ceil(step[n]/10)).
  - The output sample is the new predictor.
- R8: In mu-law mode each byte b is decoded as follows:
  - Take u=~b and t=((u&15)*8+132)<<((u>>4)&7).
  - The sample is 132-t when u bit 7 is set, and t-132 otherwise.
- R9: A sample tick is issued each time the accumulator, increased by `cfgRate` every clock, reaches CLK_HZ; CLK_HZ is then subtracted. When the clock count per sample is an integer of at least 5 and memory answers one cycle after a request, consecutive strobes are exactly CLK_HZ/`cfgRate` cycles apart.
- R10: `sampleOut` equals the decoded sample times `cfgVolume`, shifted right arithmetically by 8. A volume of 0 gives all-zero samples.
- R11: `memReq` stays high with a stable `memAddr` until `memValid` is seen. Exactly one byte is taken per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominally CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| cfgStart | input | ADDR_W | Buffer start byte address (bits 2:0 ignored) |
| cfgLength | input | ADDR_W | Buffer length in bytes (bits 2:0 ignored) |
| cfgRate | input | 16 | Sample rate in Hz |
| cfgFormat | input | 2 | 0 PCM, 1 mu-law, 2 ADPCM |
| cfgLoop | input | 1 | 1 selects continuous playback |
| cfgVolume | input | 8 | Output gain, 255 is maximum |
| playWr | input | 1 | One-cycle write of 1 to the play flag |
| playBusy | output | 1 | Play flag: 1 while playback runs |
| memReq | output | 1 | Byte read request |
| memAddr | output | ADDR_W | Byte read address |
| memValid | input | 1 | Read data valid |
| memData | input | 8 | Read data byte |
| sampleOut | output | 16 | Signed scaled sample |
| sampleStb | output | 1 | One-cycle strobe marking a new sample |

## Verification
The handshake property assumes that memory never raises `memValid` without a pending request. It also assumes that software does not restart a running playback while a fetch is outstanding. The bench memory answers exactly one cycle after each request and issues restarts only as zero-length stops or from idle. The pacing check also relies on the configuration being held steady during playback, which every scenario task does by setting it before the play write.

// File: rtl/audio_pkg.sv
package audio_pkg;
  typedef enum logic [1:0] {
    FMT_PCM8  = 2'd0,
    FMT_ULAW  = 2'd1,
    FMT_ADPCM = 2'd2,
    FMT_RSVD  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic       emit;
    logic       codecReset;
    logic       hiNibble;
    logic [7:0] byteVal;
  } dp_cmd_t;

  localparam int STEP_N   = 89;
  localparam int STEP_MAX = 88;
endpackage

// File: rtl/audio_ctrl.sv
module audio_ctrl
  import audio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CLK_HZ = 48_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfgStart,
  input  logic [ADDR_W-1:0] cfgLength,
  input  logic [15:0]       cfgRate,
  input  logic [1:0]        cfgFormat,
  input  logic              cfgLoop,
  input  logic              playWr,
  output logic              playBusy,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [7:0]        memData,
  output dp_cmd_t           dpCmd
);
  localparam int ACC_W = $clog2(CLK_HZ + 65536) + 1;
  localparam logic [ACC_W-1:0] LIMIT = ACC_W'(CLK_HZ);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_READY} st_e;

  st_e               st;
  logic [ADDR_W-1:0] curAddr, remain, baseAddr, baseLen;
  logic [ACC_W-1:0]  acc;
  logic              tick, tickPend, hiNib, codecRst;
  logic [7:0]        byteReg;

  logic [ADDR_W-1:0] startAl, lenAl;
  logic [ACC_W-1:0]  accSum;
  logic              fireNow, secondHalf, lastByte;

  assign startAl    = {cfgStart[ADDR_W-1:3], 3'b000};
  assign lenAl      = {cfgLength[ADDR_W-1:3], 3'b000};
  assign accSum     = acc + ACC_W'(cfgRate);
  assign fireNow    = (st == S_READY) && (tick || tickPend) && !playWr;
  assign secondHalf = (cfgFormat == FMT_ADPCM) && !hiNib;
  assign lastByte   = (remain == ADDR_W'(1));

  assign memReq  = (st == S_FETCH);
  assign memAddr = curAddr;
  assign dpCmd   = '{emit: fireNow, codecReset: codecRst, hiNibble: hiNib, byteVal: byteReg};

  // Sample-rate pacer
  always_ff @(posedge clk) begin
    if (rst || !playBusy || playWr) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (accSum >= LIMIT) begin
      acc  <= accSum - LIMIT;
      tick <= 1'b1;
    end else begin
      acc  <= accSum;
      tick <= 1'b0;
    end
  end

  // Address sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      playBusy <= 1'b0;
      curAddr  <= '0;
      remain   <= '0;
      baseAddr <= '0;
      baseLen  <= '0;
      tickPend <= 1'b0;
      hiNib    <= 1'b0;
      codecRst <= 1'b0;
      byteReg  <= '0;
    end else begin
      codecRst <= 1'b0;
      if (playWr) begin
        tickPend <= 1'b0;
        hiNib    <= 1'b0;
        if (lenAl != '0) begin
          baseAddr <= startAl;
          baseLen  <= lenAl;
          curAddr  <= startAl;
          remain   <= lenAl;
          st       <= S_FETCH;
          playBusy <= 1'b1;
          codecRst <= 1'b1;
        end else begin
          st       <= S_IDLE;
          playBusy <= 1'b0;
        end
      end else begin
        if (fireNow)   tickPend <= 1'b0;
        else if (tick) tickPend <= 1'b1;
        case (st)
          S_FETCH: if (memValid) begin
            byteReg <= memData;
            st      <= S_READY;
          end
          S_READY: if (fireNow) begin
            if (secondHalf) begin
              hiNib <= 1'b1;
            end else begin
              hiNib <= 1'b0;
              if (!lastByte) begin
                curAddr <= curAddr + ADDR_W'(1);
                remain  <= remain - ADDR_W'(1);
                st      <= S_FETCH;
              end else if (cfgLoop) begin
                curAddr  <= baseAddr;
                remain   <= baseLen;
                codecRst <= 1'b1;
                st       <= S_FETCH;
              end else begin
                st       <= S_IDLE;
                playBusy <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: a request is held, address unchanged, until data arrives
  p_hold_req_r11: assert property (@(posedge clk) disable iff (rst)
    memReq && !memValid && !playWr |=> memReq && $stable(memAddr));

  // R3: first fetch after a start is on an 8-byte boundary
  p_align_r3: assert property (@(posedge clk) disable iff (rst)
    playWr && (lenAl != '0) |=> memReq && (memAddr[2:0] == 3'b000));

  // R6: zero-length play write stops
  p_zero_stop_r6: assert property (@(posedge clk) disable iff (rst)
    playWr && (lenAl == '0) |=> !playBusy && !memReq);

  // R4: busy only drops on a stop or at the end of a single shot
  p_busy_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(playBusy) |-> $past(playWr) || !$past(cfgLoop));
endmodule

// File: rtl/audio_dpath.sv
module audio_dpath
  import audio_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  dp_cmd_t            dpCmd,
  input  logic [1:0]         cfgFormat,
  input  logic [7:0]         cfgVolume,
  output logic signed [15:0] sampleOut,
  output logic               sampleStb
);
  function automatic int stepCalc(input int n);
    int s;
    s = 7;
    for (int i = 0; i < n; i++) begin
      s = s + (s + 9) / 10;
      if (s > 32767) s = 32767;
    end
    return s;
  endfunction

  logic [14:0] stepRom [STEP_N];
  for (genvar g = 0; g < STEP_N; g++) begin : gStep
    localparam int STEP_V = stepCalc(g);
    assign stepRom[g] = 15'(STEP_V);
  end

  logic signed [15:0] pred;
  logic [6:0]         idx;

  logic [3:0]         nib;
  logic [14:0]        step;
  logic [16:0]        diffU;
  logic signed [18:0] predWide;
  logic signed [15:0] predNext, pcmVal, ulawVal, decoded;
  logic signed [7:0]  adj, idxWide;
  logic [6:0]         idxNext;
  logic [7:0]         uInv;
  logic [15:0]        ulawT;
  logic signed [24:0] prod;

  always_comb begin
    nib   = dpCmd.hiNibble ? dpCmd.byteVal[7:4] : dpCmd.byteVal[3:0];
    step  = stepRom[idx];
    diffU = 17'(step >> 3);
    if (nib[2]) diffU = diffU + 17'(step);
    if (nib[1]) diffU = diffU + 17'(step >> 1);
    if (nib[0]) diffU = diffU + 17'(step >> 2);
    predWide = nib[3] ? (19'(pred) - $signed({2'b00, diffU}))
                      : (19'(pred) + $signed({2'b00, diffU}));
    if (predWide > 19'sd32767)       predNext = 16'sh7FFF;
    else if (predWide < -19'sd32768) predNext = -16'sh8000;
    else                             predNext = predWide[15:0];

    adj     = nib[2] ? $signed({5'b00000, nib[1:0], 1'b0} + 8'd2) : -8'sd1;
    idxWide = $signed({1'b0, idx}) + adj;
    if (idxWide < 0)                        idxNext = 7'd0;
    else if (idxWide > 8'(STEP_MAX))        idxNext = 7'(STEP_MAX);
    else                                    idxNext = idxWide[6:0];

    pcmVal  = $signed({dpCmd.byteVal, 8'h00});
    uInv    = ~dpCmd.byteVal;
    ulawT   = ({12'd0, uInv[3:0]} << 3) + 16'd132;
    ulawT   = ulawT << uInv[6:4];
    ulawVal = uInv[7] ? $signed(16'd132 - ulawT) : $signed(ulawT - 16'd132);

    case (cfgFormat)
      FMT_ULAW:  decoded = ulawVal;
      FMT_ADPCM: decoded = predNext;
      default:   decoded = pcmVal;
    endcase
    prod = 25'(decoded) * 25'($signed({1'b0, cfgVolume}));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred      <= '0;
      idx       <= '0;
      sampleOut <= '0;
      sampleStb <= 1'b0;
    end else begin
      sampleStb <= dpCmd.emit;
      if (dpCmd.emit) sampleOut <= prod[23:8];
      if (dpCmd.codecReset) begin
        pred <= '0;
        idx  <= '0;
      end else if (dpCmd.emit && cfgFormat == FMT_ADPCM) begin
        pred <= predNext;
        idx  <= idxNext;
      end
    end
  end

  // R5: codec state is cleared after a start or wrap request
  p_codec_reset_r5: assert property (@(posedge clk) disable iff (rst)
    dpCmd.codecReset |=> (pred == 16'sd0) && (idx == 7'd0));

  // R7: step index stays inside the table
  p_index_range_r7: assert property (@(posedge clk) disable iff (rst)
    dpCmd.emit |=> idx <= 7'(STEP_MAX));

  // R10: zero volume yields silence
  p_volume_zero_r10: assert property (@(posedge clk) disable iff (rst)
    dpCmd.emit && (cfgVolume == 8'd0) |=> sampleStb && (sampleOut == 16'sd0));

  // R9: strobe only one cycle after an emit request
  p_strobe_emit_r9: assert property (@(posedge clk) disable iff (rst)
    sampleStb |-> $past(dpCmd.emit));
endmodule

// File: rtl/audio_player.sv
module audio_player
  import audio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CLK_HZ = 48_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfgStart,
  input  logic [ADDR_W-1:0] cfgLength,
  input  logic [15:0]       cfgRate,
  input  logic [1:0]        cfgFormat,
  input  logic              cfgLoop,
  input  logic [7:0]        cfgVolume,
  input  logic              playWr,
  output logic              playBusy,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [7:0]        memData,
  output logic [15:0]       sampleOut,
  output logic              sampleStb
);
  dp_cmd_t            dpCmd;
  logic signed [15:0] sampleS;

  audio_ctrl #(.ADDR_W(ADDR_W), .CLK_HZ(CLK_HZ)) u_ctrl (
    .clk(clk), .rst(rst), .cfgStart(cfgStart), .cfgLength(cfgLength),
    .cfgRate(cfgRate), .cfgFormat(cfgFormat), .cfgLoop(cfgLoop),
    .playWr(playWr), .playBusy(playBusy), .memReq(memReq),
    .memAddr(memAddr), .memValid(memValid), .memData(memData), .dpCmd(dpCmd)
  );

  audio_dpath u_dpath (
    .clk(clk), .rst(rst), .dpCmd(dpCmd), .cfgFormat(cfgFormat),
    .cfgVolume(cfgVolume), .sampleOut(sampleS), .sampleStb(sampleStb)
  );

  assign sampleOut = sampleS;
endmodule

// File: tb/audio_player_tb.sv
module audio_player_tb;
  localparam int AW  = 8;
  localparam int CHZ = 48000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cfgStart = '0, cfgLength = '0;
  logic [15:0]   cfgRate = 16'd8000;
  logic [1:0]    cfgFormat = 2'd0;
  logic          cfgLoop = 1'b0;
  logic [7:0]    cfgVolume = 8'hFF;
  logic          playWr = 1'b0;
  logic          playBusy, memReq, memValid = 1'b0, sampleStb;
  logic [AW-1:0] memAddr;
  logic [7:0]    memData = '0;
  logic [15:0]   sampleOut;

  logic [7:0] mem [256];
  int got[$];
  int gotCyc[$];
  int cyc = 0;
  int nChecks = 0, nFails = 0;
  int mPred, mIdx;

  always #5 clk = ~clk;

  audio_player #(.ADDR_W(AW), .CLK_HZ(CHZ)) u_dut (
    .clk(clk), .rst(rst), .cfgStart(cfgStart), .cfgLength(cfgLength),
    .cfgRate(cfgRate), .cfgFormat(cfgFormat), .cfgLoop(cfgLoop),
    .cfgVolume(cfgVolume), .playWr(playWr), .playBusy(playBusy),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid),
    .memData(memData), .sampleOut(sampleOut), .sampleStb(sampleStb)
  );

  always @(posedge clk) begin
    memValid <= memReq && !memValid;
    memData  <= mem[memAddr];
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (sampleStb) begin
      got.push_back(int'($signed(sampleOut)));
      gotCyc.push_back(cyc);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int scaleV(input int s, input int v);
    return (s * v) >>> 8;
  endfunction
  function automatic int pcmM(input logic [7:0] b);
    return int'($signed(b)) * 256;
  endfunction
  function automatic int ulawM(input logic [7:0] b);
    int u, t;
    u = int'(~b) & 255;
    t = ((u & 15) * 8 + 132) << ((u >> 4) & 7);
    return (u & 128) != 0 ? 132 - t : t - 132;
  endfunction
  function automatic int stepM(input int n);
    int s = 7;
    for (int i = 0; i < n; i++) begin
      s = s + (s + 9) / 10;
      if (s > 32767) s = 32767;
    end
    return s;
  endfunction
  task automatic adpcmM(input int code, output int res);
    int st, d;
    st = stepM(mIdx);
    d  = st >> 3;
    if (code & 4) d += st;
    if (code & 2) d += st >> 1;
    if (code & 1) d += st >> 2;
    mPred = (code & 8) ? mPred - d : mPred + d;
    if (mPred > 32767) mPred = 32767;
    if (mPred < -32768) mPred = -32768;
    mIdx = mIdx + (((code & 7) < 4) ? -1 : 2 * (code & 3) + 2);
    if (mIdx < 0) mIdx = 0;
    if (mIdx > 88) mIdx = 88;
    res = mPred;
  endtask

  task automatic startPlay(input int st, input int len, input int fmt,
                           input bit lp, input int vol);
    @(negedge clk);
    cfgStart = AW'(st); cfgLength = AW'(len); cfgFormat = 2'(fmt);
    cfgLoop = lp; cfgVolume = 8'(vol);
    got.delete(); gotCyc.delete();
    playWr = 1'b1;
    @(negedge clk);
    playWr = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 5000 && playBusy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic stopPlay();
    @(negedge clk);
    cfgLength = '0;
    playWr = 1'b1;
    @(negedge clk);
    playWr = 1'b0;
  endtask

  task automatic testReset();
    chk(playBusy == 1'b0, "R4 reset busy", int'(playBusy), 0);
    chk(memReq == 1'b0, "R11 reset req", int'(memReq), 0);
    chk(sampleStb == 1'b0 && sampleOut == 16'd0, "R10 reset out", int'(sampleOut), 0);
  endtask

  task automatic testPcm();
    bit ok = 1;
    startPlay(8'h40, 16, 0, 1'b0, 8'hFF);
    chk(playBusy == 1'b1, "R4 busy after play", int'(playBusy), 1);
    waitIdle();
    chk(playBusy == 1'b0, "R4 busy clears", int'(playBusy), 0);
    chk(got.size() == 16, "R2 pcm count", got.size(), 16);
    for (int i = 0; i < 16 && i < got.size(); i++)
      chk(got[i] == scaleV(pcmM(mem[8'h40 + i]), 255), "R2 pcm value R1", got[i],
          scaleV(pcmM(mem[8'h40 + i]), 255));
    for (int i = 1; i < gotCyc.size(); i++)
      if (gotCyc[i] - gotCyc[i-1] != CHZ / 8000) begin
        chk(1'b0, "R9 spacing", gotCyc[i] - gotCyc[i-1], CHZ / 8000);
        ok = 0;
      end
    if (ok) chk(1'b1, "R9 spacing", 0, 0);
  endtask

  task automatic testAlign();
    startPlay(8'h63, 8'h0D, 0, 1'b0, 8'hFF);
    waitIdle();
    chk(got.size() == 8, "R3 aligned count", got.size(), 8);
    for (int i = 0; i < 8 && i < got.size(); i++)
      chk(got[i] == scaleV(pcmM(mem[8'h60 + i]), 255), "R3 aligned data", got[i],
          scaleV(pcmM(mem[8'h60 + i]), 255));
  endtask

  task automatic testUlaw();
    startPlay(8'h80, 8, 1, 1'b0, 8'h80);
    waitIdle();
    chk(got.size() == 8, "R8 ulaw count", got.size(), 8);
    for (int i = 0; i < 8 && i < got.size(); i++)
      chk(got[i] == scaleV(ulawM(mem[8'h80 + i]), 128), "R8 ulaw value", got[i],
          scaleV(ulawM(mem[8'h80 + i]), 128));
  endtask

  task automatic testAdpcm();
    int e;
    startPlay(8'h90, 8, 2, 1'b0, 8'hFF);
    waitIdle();
    chk(got.size() == 16, "R7 adpcm count", got.size(), 16);
    mPred = 0; mIdx = 0;
    for (int i = 0; i < 16 && i < got.size(); i++) begin
      adpcmM((i % 2 == 0) ? int'(mem[8'h90 + i/2][3:0]) : int'(mem[8'h90 + i/2][7:4]), e);
      chk(got[i] == scaleV(e, 255), "R7 adpcm value", got[i], scaleV(e, 255));
    end
  endtask

  task automatic testLoop();
    int e, n;
    int ref16[16];
    mPred = 0; mIdx = 0;
    for (int i = 0; i < 16; i++) begin
      adpcmM((i % 2 == 0) ? int'(mem[8'h90 + i/2][3:0]) : int'(mem[8'h90 + i/2][7:4]), e);
      ref16[i] = scaleV(e, 255);
    end
    startPlay(8'h90, 8, 2, 1'b1, 8'hFF);
    for (int i = 0; i < 5000 && got.size() < 40; i++) @(negedge clk);
    chk(playBusy == 1'b1, "R5 still busy", int'(playBusy), 1);
    stopPlay();
    chk(playBusy == 1'b0, "R6 stop busy", int'(playBusy), 0);
    @(negedge clk);
    n = got.size();
    repeat (40) @(negedge clk);
    chk(got.size() == n, "R6 no strobe after stop", got.size(), n);
    chk(memReq == 1'b0, "R6 no req after stop", int'(memReq), 0);
    chk(n >= 40, "R5 loop count", n, 40);
    for (int i = 0; i < 40 && i < n; i++)
      chk(got[i] == ref16[i % 16], "R5 wrap repeats", got[i], ref16[i % 16]);
  endtask

  task automatic testZeroIdle();
    bit sawReq = 0;
    startPlay(8'h40, 8'h05, 0, 1'b0, 8'hFF);
    for (int i = 0; i < 20; i++) begin
      if (memReq || playBusy) sawReq = 1;
      @(negedge clk);
    end
    chk(!sawReq, "R6 zero length from idle", int'(sawReq), 0);
    chk(got.size() == 0, "R6 no samples", got.size(), 0);
  endtask

  task automatic testVolZero();
    bit ok = 1;
    startPlay(8'h40, 8, 0, 1'b0, 8'h00);
    waitIdle();
    chk(got.size() == 8, "R10 vol0 count", got.size(), 8);
    foreach (got[i]) if (got[i] != 0) ok = 0;
    chk(ok, "R10 vol0 silent", ok, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
    mem[8'h80] = 8'h00; mem[8'h81] = 8'hFF; mem[8'h82] = 8'h80; mem[8'h83] = 8'h7F;
    mem[8'h84] = 8'h55; mem[8'h85] = 8'hAA; mem[8'h86] = 8'h0F; mem[8'h87] = 8'hF0;
    mem[8'h90] = 8'h77; mem[8'h91] = 8'h7F; mem[8'h92] = 8'h07; mem[8'h93] = 8'h8C;
    mem[8'h94] = 8'hF9; mem[8'h95] = 8'h21; mem[8'h96] = 8'h3E; mem[8'h97] = 8'hB5;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testPcm();
    testAlign();
    testUlaw();
    testAdpcm();
    testLoop();
    testZeroIdle();
    testVolZero();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #1500000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule